// File: doc/BRIEF.md
# ID-framed serial bus master

This block is the controller end of a three-wire serial link made up of a clock line, an identity line and a shared data line. A host pulses `start` with an address byte, a write byte and a read/write flag. The engine then runs one complete frame. In the first phase, the identity line is held low while eight address bits are clocked out. The identity line then goes high, and eight more clock periods carry either the write byte from the master or the read byte from the addressed peripheral. To finish, the clock is parked high and the identity line is strobed low for a guaranteed minimum time. On the peripheral side, that strobe commits the transfer.

The clock and identity lines are push-pull outputs. The data line is open drain: the block only asserts a pull-low enable and reads the resolved line back through a separate input. Clock phases are paced by a divider whose half-period is set in system cycles. A second count sets the width of the closing identity strobe, and its default gives at least 1 µs at a 125 MHz system clock. Bits travel least significant first by default, and a parameter can reverse that order.

Top module: `idbus_master`

## Requirements
- R1: Outside a frame, `bus_clk` and `bus_id` are high, `bus_data_pull` is low (line released) and `busy` is low; this is also the state after reset, with `rdata` at zero.
- R2: A frame opens with `bus_clk` and `bus_id` falling in the same cycle. Eight address bits are then presented, least significant first, each one read by the peripheral on a `bus_clk` rising edge while `bus_id` is low.
- R3: After the eighth address rising edge, `bus_id` rises while `bus_clk` is high. Exactly eight further `bus_clk` rising edges then follow with `bus_id` high, and no other edge occurs before the closing strobe.
- R4: In a write frame, the data-phase line level at each rising edge equals the write byte, least significant bit first. A 0 bit sets `bus_data_pull` to 1, and a 1 bit leaves the line released.
- R5: In a read frame, `bus_data_pull` stays low through the data phase. The line level sampled at each data-phase rising edge is assembled least significant first into `rdata`, which is valid when `done` pulses.
- R6: After the last data edge, `bus_clk` stays high and `bus_id` is driven low for exactly END_PULSE system cycles, which satisfies the minimum strobe width, and then returns high.
- R7: `busy` rises in the cycle after an accepted `start` and falls in the same cycle that `bus_id` returns high. `done` is high for exactly that one cycle.
- R8: A `start` pulse while `busy` is high is ignored: the frame in progress carries the originally latched address and data, and no extra frame is produced.
- R9: During a frame, `bus_data_pull` never changes while `bus_clk` stays high, except together with an edge of `bus_id`. The data level is therefore held through every high phase.
- R10: A write frame leaves `rdata` unchanged.
- R11: Every `bus_clk` low phase inside a frame lasts exactly HALF_PER system cycles, and a new data bit is set at the start of that low phase, giving one full half-period of setup before the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run a frame |
| addr | input | ADDR_W | Address byte sent with the identity line low |
| wdata | input | DATA_W | Byte sent in the data phase of a write |
| rd_en | input | 1 | 1 selects a read frame, 0 a write frame |
| rdata | output | DATA_W | Byte captured by the last read frame |
| done | output | 1 | One-cycle pulse when a frame completes |
| busy | output | 1 | High while a frame is in progress |
| bus_clk | output | 1 | Serial clock line, push-pull |
| bus_id | output | 1 | Identity line, push-pull |
| bus_data_pull | output | 1 | 1 pulls the open-drain data line low |
| bus_data_in | input | 1 | Resolved level of the data line |

## Verification
The bench builds the block with HALF_PER = 3 and END_PULSE = 5 at the default 8-bit widths and LSB-first order. These small counts keep each frame to roughly a hundred cycles, so several reads and writes fit in one run. They also let every low phase and the closing strobe be timed to the exact cycle. A peripheral model on the bench pulls the line low during read data phases. This exposes any case where the master drives the line in a read, or where it samples on the wrong edge. Address and data patterns are chosen to reach all-zero, all-one, single-bit and alternating values, and a stray `start` is injected in the middle of one frame.

// File: rtl/idb_pkg.sv
package idb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_GAP,
      ST_DATA,
      ST_STOP,
      ST_ENDP
   } idb_state_e;
endpackage

// File: rtl/idb_halftimer.sv
module idb_halftimer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             tick
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign tick = (cnt == '0);
endmodule

// File: rtl/idb_rxshift.sv
module idb_rxshift #(
   parameter int unsigned W         = 8,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         shift_en,
   input  logic         bit_in,
   output logic [W-1:0] word
);
   generate
      if (W < 2) begin : g_bad_w
         $error("idb_rxshift: W must be at least 2");
      end
      if (LSB_FIRST) begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        word <= '0;
            else if (clear)    word <= '0;
            else if (shift_en) word <= {bit_in, word[W-1:1]};
         end
      end else begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        word <= '0;
            else if (clear)    word <= '0;
            else if (shift_en) word <= {word[W-2:0], bit_in};
         end
      end
   endgenerate
endmodule

// File: rtl/idbus_master.sv
module idbus_master
   import idb_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned HALF_PER  = 16,
   parameter int unsigned END_PULSE = 128,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rdata,
   output logic              done,
   output logic              busy,
   output logic              bus_clk,
   output logic              bus_id,
   output logic              bus_data_pull,
   input  logic              bus_data_in
);
   localparam int unsigned MAXCNT = (HALF_PER > END_PULSE) ? HALF_PER : END_PULSE;
   localparam int unsigned CNT_W  = $clog2(MAXCNT + 1);
   localparam int unsigned MAXW   = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
   localparam int unsigned IDX_W  = $clog2(MAXW);
   localparam int unsigned LW     = $clog2(END_PULSE + 2);
   localparam logic [CNT_W-1:0] HALF_LD = CNT_W'(HALF_PER - 1);
   localparam logic [CNT_W-1:0] END_LD  = CNT_W'(END_PULSE - 1);
   localparam logic [IDX_W-1:0] LAST_A  = IDX_W'(ADDR_W - 1);
   localparam logic [IDX_W-1:0] LAST_D  = IDX_W'(DATA_W - 1);

   generate
      if (HALF_PER < 1) begin : g_chk_half
         $error("idbus_master: HALF_PER must be at least 1");
      end
      if (END_PULSE < 1) begin : g_chk_end
         $error("idbus_master: END_PULSE must be at least 1");
      end
      if (ADDR_W < 2 || DATA_W < 2) begin : g_chk_w
         $error("idbus_master: ADDR_W and DATA_W must be at least 2");
      end
   endgenerate

   // Bit order: reorder once so the shifter always sends bit 0 first
   logic [ADDR_W-1:0] addr_ord;
   logic [DATA_W-1:0] wdata_ord;
   generate
      if (LSB_FIRST) begin : g_ord_lsb
         assign addr_ord  = addr;
         assign wdata_ord = wdata;
      end else begin : g_ord_msb
         for (genvar i = 0; i < ADDR_W; i++) begin : g_a
            assign addr_ord[i] = addr[ADDR_W-1-i];
         end
         for (genvar j = 0; j < DATA_W; j++) begin : g_d
            assign wdata_ord[j] = wdata[DATA_W-1-j];
         end
      end
   endgenerate

   idb_state_e        state;
   logic              high_ph;
   logic [IDX_W-1:0]  bit_idx;
   logic [MAXW-1:0]   tx;
   logic [DATA_W-1:0] d_q;
   logic              rd_q;
   logic              clk_r, id_r, pull_r, busy_r, done_r;
   logic [DATA_W-1:0] rdata_r;
   logic [DATA_W-1:0] rx_word;
   logic              tick;
   logic              accept;
   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;
   logic              last_bit;

   assign accept   = (state == ST_IDLE) && start;
   assign tmr_load = accept || ((state != ST_IDLE) && tick);
   assign tmr_val  = (state == ST_STOP) ? END_LD : HALF_LD;
   assign last_bit = (bit_idx == ((state == ST_ADDR) ? LAST_A : LAST_D));

   idb_halftimer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .tick     (tick)
   );

   idb_rxshift #(.W(DATA_W), .LSB_FIRST(LSB_FIRST)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (accept),
      .shift_en ((state == ST_DATA) && !high_ph && tick && rd_q),
      .bit_in   (bus_data_in),
      .word     (rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         high_ph <= 1'b0;
         bit_idx <= '0;
         tx      <= '0;
         d_q     <= '0;
         rd_q    <= 1'b0;
         clk_r   <= 1'b1;
         id_r    <= 1'b1;
         pull_r  <= 1'b0;
         busy_r  <= 1'b0;
         done_r  <= 1'b0;
         rdata_r <= '0;
      end else begin
         done_r <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               state   <= ST_ADDR;
               high_ph <= 1'b0;
               bit_idx <= '0;
               clk_r   <= 1'b0;
               id_r    <= 1'b0;
               busy_r  <= 1'b1;
               rd_q    <= rd_en;
               d_q     <= wdata_ord;
               tx      <= MAXW'(addr_ord);
               pull_r  <= ~addr_ord[0];
            end
            ST_ADDR, ST_DATA: if (tick) begin
               if (!high_ph) begin
                  high_ph <= 1'b1;
                  clk_r   <= 1'b1;
               end else if (last_bit) begin
                  // clock stays parked high between phases
                  if (state == ST_ADDR) begin
                     state <= ST_GAP;
                     id_r  <= 1'b1;
                  end else begin
                     state <= ST_STOP;
                  end
               end else begin
                  high_ph <= 1'b0;
                  clk_r   <= 1'b0;
                  bit_idx <= bit_idx + 1'b1;
                  tx      <= tx >> 1;
                  pull_r  <= (state == ST_DATA && rd_q) ? 1'b0 : ~tx[1];
               end
            end
            ST_GAP: if (tick) begin
               state   <= ST_DATA;
               high_ph <= 1'b0;
               bit_idx <= '0;
               clk_r   <= 1'b0;
               tx      <= MAXW'(d_q);
               pull_r  <= rd_q ? 1'b0 : ~d_q[0];
            end
            ST_STOP: if (tick) begin
               state  <= ST_ENDP;
               id_r   <= 1'b0;
               pull_r <= 1'b0;
            end
            ST_ENDP: if (tick) begin
               state  <= ST_IDLE;
               id_r   <= 1'b1;
               busy_r <= 1'b0;
               done_r <= 1'b1;
               if (rd_q) rdata_r <= rx_word;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign bus_clk       = clk_r;
   assign bus_id        = id_r;
   assign bus_data_pull = pull_r;
   assign busy          = busy_r;
   assign done          = done_r;
   assign rdata         = rdata_r;

   // Strobe width monitor: cycles with identity low while clock is high
   logic [LW-1:0] low_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 low_cnt <= '0;
      else if (!clk_r || id_r)    low_cnt <= '0;
      else if (low_cnt != '1)     low_cnt <= low_cnt + 1'b1;
   end

   assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_r |-> (clk_r && id_r && !pull_r));

   assert_id_rise_clk_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(id_r) |-> clk_r);

   assert_end_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(id_r) && !busy_r) |-> (low_cnt >= LW'(END_PULSE)));

   assert_busy_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_r && start) |=> busy_r);

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_r |=> !done_r);

   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_r |-> !busy_r);

   assert_pull_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_r && $past(clk_r) && (id_r == $past(id_r))) |-> $stable(pull_r));
endmodule

// File: tb/idbus_master_tb.sv
`timescale 1ns/1ps
module idbus_master_tb;
   localparam int HALF = 3;
   localparam int ENDP = 5;
   localparam int PER  = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rdata;
   logic       done, busy, bus_clk, bus_id, bus_data_pull;
   logic       line;
   logic       slave_low = 1'b0;
   logic       cur_rd = 1'b0;
   logic [7:0] slave_byte = '0;
   int         k = 0;
   int         rises = 0;
   int         total = 0;
   int         fails = 0;
   int         frames = 0;

   typedef struct { logic [7:0] a; logic [7:0] d; bit rd; } item_t;
   item_t sb_q[$];

   always #(PER/2) clk = ~clk;

   assign line = !(bus_data_pull || slave_low);

   idbus_master #(.HALF_PER(HALF), .END_PULSE(ENDP)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .wdata(wdata),
      .rd_en(rd_en), .rdata(rdata), .done(done), .busy(busy),
      .bus_clk(bus_clk), .bus_id(bus_id), .bus_data_pull(bus_data_pull),
      .bus_data_in(line)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Peripheral model: counts data-phase edges, drives read bits in low phases
   always @(posedge bus_clk) rises++;
   always @(posedge bus_clk or negedge bus_id) begin
      if (!bus_id) k = 0;
      else if (busy) k = k + 1;
   end
   always @(negedge bus_clk or negedge bus_id) begin
      if (!bus_id) slave_low = 1'b0;
      else if (busy && cur_rd && k < 8) slave_low = ~slave_byte[k];
      else slave_low = 1'b0;
   end

   // Monitor: observes each frame on the wires and compares with the scoreboard
   initial begin : monitor
      forever begin
         logic [7:0] got_a, got_d;
         bit id_ok, low_ok, hold_ok;
         time tf, te;
         int base;
         item_t it;
         @(negedge bus_id);
         tf = $time; base = rises;
         id_ok = 1; low_ok = 1; hold_ok = 1; got_a = '0; got_d = '0;
         for (int i = 0; i < 16; i++) begin
            logic v;
            if (i > 0) begin
               @(negedge bus_clk);
               tf = $time;
            end
            @(posedge bus_clk);
            if (($time - tf) != HALF*PER) low_ok = 0;
            v = line;
            if (i < 8) got_a[i] = v; else got_d[i-8] = v;
            if (bus_id != (i >= 8)) id_ok = 0;
            #(HALF*PER - 4);
            if (line != v) hold_ok = 0;
         end
         @(negedge bus_id);
         te = $time;
         check(rises - base == 16, "R3 edge count", rises - base, 16);
         check(bus_clk == 1'b1, "R6 clock parked high", bus_clk, 1);
         @(posedge bus_id);
         check(($time - te) == ENDP*PER, "R6 strobe width", ($time - te)/PER, ENDP);
         if (sb_q.size() == 0) begin
            check(0, "R8 unexpected frame", frames, 0);
         end else begin
            it = sb_q.pop_front();
            check(got_a == it.a, "R2 address bits", got_a, it.a);
            check(got_d == it.d, it.rd ? "R5 read line" : "R4 write bits", got_d, it.d);
         end
         check(id_ok, "R3 identity level", id_ok, 1);
         check(low_ok, "R11 low phase length", low_ok, 1);
         check(hold_ok, "R9 data held in high phase", hold_ok, 1);
         frames++;
      end
   end

   logic [7:0] exp_rdata = '0;

   // Driver: pushes expected frame, starts it, checks host-side results
   task automatic xfer(input logic [7:0] a, input logic [7:0] d, input bit rd,
                       input logic [7:0] sbyte, input bit inject);
      item_t it;
      @(negedge clk);
      it.a = a; it.d = rd ? sbyte : d; it.rd = rd;
      sb_q.push_back(it);
      cur_rd = rd; slave_byte = sbyte;
      addr = a; wdata = d; rd_en = rd; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R7 busy after start", busy, 1);
      if (inject) begin
         repeat (HALF*4) @(negedge clk);
         addr = ~a; wdata = ~d; rd_en = ~rd; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      check(busy == 1'b0, "R7 busy falls with done", busy, 0);
      if (rd) begin
         exp_rdata = sbyte;
         check(rdata == sbyte, "R5 read data", rdata, sbyte);
      end else begin
         check(rdata == exp_rdata, "R10 rdata kept on write", rdata, exp_rdata);
      end
      @(negedge clk);
      check(done == 1'b0, "R7 done one cycle", done, 0);
      check(bus_clk && bus_id && !bus_data_pull, "R1 idle lines",
            {bus_clk, bus_id, bus_data_pull}, 3'b110);
   endtask

   initial begin : watchdog
      #(PER*150000);
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(bus_clk && bus_id && !bus_data_pull && !busy && !done, "R1 reset state",
            {bus_clk, bus_id, bus_data_pull, busy, done}, 5'b11000);
      check(rdata == 8'h00, "R1 reset rdata", rdata, 0);
      xfer(8'h40, 8'hA5, 1'b0, 8'h00, 1'b0);
      xfer(8'h47, 8'h00, 1'b1, 8'h3C, 1'b0);
      xfer(8'h81, 8'h01, 1'b0, 8'h00, 1'b1);
      xfer(8'hFF, 8'h00, 1'b1, 8'h80, 1'b0);
      xfer(8'h00, 8'hFF, 1'b0, 8'h00, 1'b0);
      repeat (20) @(negedge clk);
      check(frames == 5, "R8 frame count", frames, 5);
      check(sb_q.size() == 0, "R8 scoreboard drained", sb_q.size(), 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule